// File: doc/BRIEF.md
# Synchronous Serial Transmitter with Clock Output

This block sends parallel words as serial frames on a single data line and, at the same time, drives a serial clock pin so that a receiver with no clock of its own can sample every data bit. A word enters through a valid/ready handshake. The frame is one low start bit, then 7, 8 or 9 data bits least significant bit first, then one high stop bit. Every bit period lasts a programmable number of system clock cycles.

During data bits the clock pin carries one pulse per bit. The pulse edges sit at one quarter and three quarters of the bit period. The idle level of the pin, which of the two edges is the capture edge, and whether the last data bit gets a pulse can all be configured. These clock-shape settings, together with the clock-output enable, are taken only while the block is disabled. While it is enabled they stay frozen. Dropping the enable abandons a frame in progress at once.

Top module: `usart_sync_tx`

## Requirements
- R1: While no frame is in progress, txOut is high and sclkOut holds the idle level. After reset with cpol low, txOut is 1, sclkOut is 0 and inReady is 0.
- R2: A frame is a low start bit, the data bits LSB first and a high stop bit. Each bit lasts D system cycles, where D is baudDiv, and any baudDiv below 4 counts as 4. With cpha at 0, the start bit appears on txOut in the second cycle after the handshake cycle's clock edge.
- R3: wordLen selects the number of data bits: 2'b00 selects 8, 2'b01 selects 9, 2'b10 selects 7 and 2'b11 selects 8. The last data bit sent is the most significant bit of that length.
- R4: With the clock output disabled, sclkOut holds the polarity level for the whole frame.
- R5: With the clock output enabled, sclkOut sits at the inverse of the polarity level for cycles floor(D/4) up to floor(3D/4)-1 of each data-bit period, on the same latency as txOut. At every other time, including start and stop bits, it sits at the polarity level.
- R6: With cpha at 0, txOut changes at the start of each bit period, so the first clock edge captures. With cpha at 1, the whole txOut frame is delayed by floor(D/4) cycles, so data changes together with the first clock edge and the second edge captures.
- R7: With lastPulse at 0, no pulse appears during the final data bit. With lastPulse at 1, that pulse appears.
- R8: clkOutEn, cpol, cpha and lastPulse are sampled only on clock edges where enable is low. Changes made while enable is high have no effect on sclkOut or txOut.
- R9: inReady is high exactly when enable is high and no frame is in progress. A word is taken on a cycle where inValid and inReady are both high, and inReady then falls.
- R10: When enable is sampled low, txOut goes high and sclkOut takes the cpol input level in the next cycle, and any frame in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low aborts and unlocks settings |
| clkOutEn | input | 1 | Drive pulses on the clock pin |
| cpol | input | 1 | Idle level of the clock pin |
| cpha | input | 1 | 0: first edge captures, 1: second edge captures |
| lastPulse | input | 1 | Emit the pulse of the final data bit |
| wordLen | input | 2 | Data bit count code |
| baudDiv | input | DIV_W | System cycles per bit (minimum 4) |
| inValid | input | 1 | Word offered |
| inData | input | 9 | Word to send, LSB first |
| inReady | output | 1 | Block can take a word |
| txOut | output | 1 | Serial data line, idles high |
| sclkOut | output | 1 | Serial clock pin |

## Verification
Frames are driven under every combination of polarity and phase, with all three word lengths. The mix covers the last pulse kept and dropped, the clock output on and off, and dividers that do and do not divide evenly by four, including one below the minimum. Each cycle of each frame is compared with a model: alternating and asymmetric data patterns expose bit order and word length, while cpha separates the shifted data timing from the fixed pulse window. Directed cases then change the locked settings while the block is enabled and drop the enable in mid-frame, and the observed pin levels show that the frozen values were honoured and that the abort took effect in the very next cycle.

// File: rtl/usart_sync_pkg.sv
`timescale 1ns/1ps
package usart_sync_pkg;

  localparam int unsigned MAX_BITS = 9;
  localparam int unsigned IDX_W    = $clog2(MAX_BITS + 2);

  typedef enum logic [1:0] {
    EMIT_IDLE,
    EMIT_START,
    EMIT_DATA,
    EMIT_STOP
  } emit_e;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic             load;   // capture the offered word
    logic             quiet;  // force both pins to idle at once
    emit_e            sel;    // what the data line shows
    logic [IDX_W-1:0] idx;    // data bit shown when sel is EMIT_DATA
    logic             pulse;  // clock pin at its active level
  } strobe_t;

  function automatic logic [IDX_W-1:0] wordBits(input logic [1:0] code);
    case (code)
      2'b01:   return IDX_W'(9);
      2'b10:   return IDX_W'(7);
      default: return IDX_W'(8);
    endcase
  endfunction

endpackage

// File: rtl/usart_sync_ctrl.sv
`timescale 1ns/1ps
module usart_sync_ctrl
  import usart_sync_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             clkOutEn,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lastPulse,
  input  logic [1:0]       wordLen,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             inValid,
  output logic             inReady,
  output logic             cpolCfg,
  output strobe_t          strb
);

  localparam int unsigned QW = DIV_W + 2;
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(4);

  // settings frozen while enabled
  logic cfgClkEn, cfgCpol, cfgCpha, cfgLast;

  logic             running;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] frameDiv;
  logic [IDX_W-1:0] bitNum;
  logic [IDX_W-1:0] frameBits;
  logic             accept;
  logic             periodEnd;

  logic [QW-1:0]    divW, q1, q3, cntW;
  logic             early, showIdle, dataPeriod, skipLast, inWindow;
  logic [IDX_W-1:0] vb;

  assign inReady   = enable && !running;
  assign accept    = inValid && inReady;
  assign periodEnd = (cnt == frameDiv - DIV_W'(1));
  assign cpolCfg   = cfgCpol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgClkEn <= 1'b0;
      cfgCpol  <= 1'b0;
      cfgCpha  <= 1'b0;
      cfgLast  <= 1'b0;
    end else if (!enable) begin
      cfgClkEn <= clkOutEn;
      cfgCpol  <= cpol;
      cfgCpha  <= cpha;
      cfgLast  <= lastPulse;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      cnt       <= '0;
      bitNum    <= '0;
      frameDiv  <= MIN_DIV;
      frameBits <= IDX_W'(8);
    end else if (!enable) begin
      running <= 1'b0;
      cnt     <= '0;
      bitNum  <= '0;
    end else if (accept) begin
      running   <= 1'b1;
      cnt       <= '0;
      bitNum    <= '0;
      frameDiv  <= (baudDiv < MIN_DIV) ? MIN_DIV : baudDiv;
      frameBits <= wordBits(wordLen);
    end else if (running) begin
      if (periodEnd) begin
        cnt <= '0;
        if (bitNum == frameBits + IDX_W'(1)) begin
          running <= 1'b0;
          bitNum  <= '0;
        end else begin
          bitNum <= bitNum + IDX_W'(1);
        end
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  // quarter points of the bit period
  always_comb begin
    divW = {2'b00, frameDiv};
    cntW = {2'b00, cnt};
    q1   = divW >> 2;
    q3   = (divW + (divW << 1)) >> 2;
  end

  always_comb begin
    strb       = '0;
    strb.sel   = EMIT_IDLE;
    strb.load  = accept;
    strb.quiet = !enable;

    // second-edge capture: data line lags by a quarter period
    early    = cfgCpha && (cntW < q1);
    vb       = bitNum;
    showIdle = !running;
    if (running && early) begin
      if (bitNum == '0) showIdle = 1'b1;
      else              vb = bitNum - IDX_W'(1);
    end

    if (!showIdle) begin
      if (vb == '0) begin
        strb.sel = EMIT_START;
      end else if (vb <= frameBits) begin
        strb.sel = EMIT_DATA;
        strb.idx = vb - IDX_W'(1);
      end else begin
        strb.sel = EMIT_STOP;
      end
    end

    dataPeriod = (bitNum != '0) && (bitNum <= frameBits);
    skipLast   = (bitNum == frameBits) && !cfgLast;
    inWindow   = (cntW >= q1) && (cntW < q3);
    strb.pulse = running && cfgClkEn && dataPeriod && !skipLast && inWindow;
  end

endmodule

// File: rtl/usart_sync_dp.sv
`timescale 1ns/1ps
module usart_sync_dp
  import usart_sync_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [MAX_BITS-1:0] inData,
  input  logic                cpolIn,
  input  logic                cpolCfg,
  output logic                txOut,
  output logic                sclkOut
);

  logic [MAX_BITS-1:0] wordReg;
  logic                txNext, sclkNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          wordReg <= '0;
    else if (strb.load) wordReg <= inData;
  end

  always_comb begin
    case (strb.sel)
      EMIT_START: txNext = 1'b0;
      EMIT_DATA:  txNext = wordReg[strb.idx];
      default:    txNext = 1'b1;
    endcase
    if (strb.quiet) begin
      txNext   = 1'b1;
      sclkNext = cpolIn;
    end else begin
      sclkNext = strb.pulse ? !cpolCfg : cpolCfg;
    end
  end

  // registered pins: no combinational glitches reach the clock pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOut   <= 1'b1;
      sclkOut <= 1'b0;
    end else begin
      txOut   <= txNext;
      sclkOut <= sclkNext;
    end
  end

endmodule

// File: rtl/usart_sync_tx.sv
`timescale 1ns/1ps
module usart_sync_tx
  import usart_sync_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                clkOutEn,
  input  logic                cpol,
  input  logic                cpha,
  input  logic                lastPulse,
  input  logic [1:0]          wordLen,
  input  logic [DIV_W-1:0]    baudDiv,
  input  logic                inValid,
  input  logic [MAX_BITS-1:0] inData,
  output logic                inReady,
  output logic                txOut,
  output logic                sclkOut
);

  strobe_t strb;
  logic    cpolCfg;

  usart_sync_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .clkOutEn (clkOutEn),
    .cpol     (cpol),
    .cpha     (cpha),
    .lastPulse(lastPulse),
    .wordLen  (wordLen),
    .baudDiv  (baudDiv),
    .inValid  (inValid),
    .inReady  (inReady),
    .cpolCfg  (cpolCfg),
    .strb     (strb)
  );

  usart_sync_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .inData (inData),
    .cpolIn (cpol),
    .cpolCfg(cpolCfg),
    .txOut  (txOut),
    .sclkOut(sclkOut)
  );

endmodule

// File: rtl/usart_sync_tx_chk.sv
`timescale 1ns/1ps
module usart_sync_tx_chk
  import usart_sync_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                enable,
  input logic                clkOutEn,
  input logic                cpol,
  input logic                cpha,
  input logic                lastPulse,
  input logic [1:0]          wordLen,
  input logic [DIV_W-1:0]    baudDiv,
  input logic                inValid,
  input logic [MAX_BITS-1:0] inData,
  input logic                inReady,
  input logic                txOut,
  input logic                sclkOut
);

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  p_ready_needs_en_r9: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    inReady |-> enable);

  p_busy_after_take_r9: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    (inValid && inReady) |=> !inReady);

  p_abort_line_r10: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    !enable |=> txOut);

  p_abort_clk_r10: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    !enable |=> (sclkOut == $past(cpol)));

  p_idle_line_r1: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    inReady |=> txOut);

  p_idle_clk_r1: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    (inReady ##1 inReady) |=> $stable(sclkOut));

endmodule

bind usart_sync_tx usart_sync_tx_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/usart_sync_tx_tb.sv
`timescale 1ns/1ps
module usart_sync_tx_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        clkOutEn = 1'b0;
  logic        cpol = 1'b0;
  logic        cpha = 1'b0;
  logic        lastPulse = 1'b0;
  logic [1:0]  wordLen = 2'b00;
  logic [15:0] baudDiv = 16'd8;
  logic        inValid = 1'b0;
  logic [8:0]  inData = '0;
  logic        inReady, txOut, sclkOut;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;

  // model of the locked configuration
  int   mN = 8, mD = 8;
  logic mCpol = 0, mCpha = 0, mClk = 0, mLast = 0;
  logic [8:0] mData = '0;

  always #4 clk = ~clk;   // 125 MHz

  usart_sync_tx u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .clkOutEn(clkOutEn),
    .cpol(cpol), .cpha(cpha), .lastPulse(lastPulse), .wordLen(wordLen),
    .baudDiv(baudDiv), .inValid(inValid), .inData(inData),
    .inReady(inReady), .txOut(txOut), .sclkOut(sclkOut)
  );

  // cpol cpha clkEn last wlen[2] div[8] data[9]
  localparam int NV = 8;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 8'd8,  9'h0A5},
    {1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 8'd8,  9'h05A},
    {1'b0, 1'b1, 1'b1, 1'b1, 2'b01, 8'd8,  9'h1C3},
    {1'b1, 1'b1, 1'b1, 1'b0, 2'b10, 8'd4,  9'h055},
    {1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 8'd10, 9'h101},
    {1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 8'd8,  9'h0FF},
    {1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 8'd2,  9'h07F},
    {1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 8'd6,  9'h0C6}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bitsOf(input logic [1:0] code);
    case (code)
      2'b01:   return 9;
      2'b10:   return 7;
      default: return 8;
    endcase
  endfunction

  function automatic logic modelTx(input int p);
    int b, c, vb, q1;
    q1 = mD / 4;
    if (p >= (mN + 2) * mD) return 1'b1;
    b = p / mD; c = p % mD; vb = b;
    if (mCpha && c < q1) begin
      if (b == 0) return 1'b1;
      vb = b - 1;
    end
    if (vb == 0) return 1'b0;
    if (vb <= mN) return mData[vb-1];
    return 1'b1;
  endfunction

  function automatic logic modelSclk(input int p);
    int b, c, q1, q3;
    logic act;
    q1 = mD / 4; q3 = (3 * mD) / 4;
    if (p >= (mN + 2) * mD || !mClk) return mCpol;
    b = p / mD; c = p % mD;
    act = (b >= 1) && (b <= mN) && !(b == mN && !mLast) && (c >= q1) && (c < q3);
    return act ? ~mCpol : mCpol;
  endfunction

  task automatic setup(input logic pol, input logic pha, input logic ce,
                       input logic lp, input logic [1:0] wl, input int dv);
    @(negedge clk);
    enable = 1'b0;
    cpol = pol; cpha = pha; clkOutEn = ce; lastPulse = lp;
    wordLen = wl; baudDiv = 16'(dv);
    @(negedge clk);
    enable = 1'b1;
    mCpol = pol; mCpha = pha; mClk = ce; mLast = lp;
    mN = bitsOf(wl); mD = (dv < 4) ? 4 : dv;
  endtask

  task automatic sendWord(input logic [8:0] d);
    @(negedge clk);
    chk("R9 inReady before offer", 32'(inReady), 32'd1);
    inValid = 1'b1; inData = d; mData = d;
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  task automatic runFrame(input logic [8:0] d);
    int frameLen;
    sendWord(d);
    frameLen = (mN + 2) * mD;
    for (int p = 0; p <= frameLen; p++) begin
      @(posedge clk);
      #2;
      chk("R2 R3 R6 txOut", 32'(txOut), 32'(modelTx(p)));
      chk("R4 R5 R7 sclkOut", 32'(sclkOut), 32'(modelSclk(p)));
      chk("R9 inReady", 32'(inReady), 32'((p + 1) >= frameLen));
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #2;
    chk("R1 txOut after reset", 32'(txOut), 32'd1);
    chk("R1 sclkOut after reset", 32'(sclkOut), 32'd0);
    chk("R1 R9 inReady while disabled", 32'(inReady), 32'd0);
    @(negedge clk) enable = 1'b1;
    #1 chk("R9 inReady once enabled", 32'(inReady), 32'd1);

    // main table
    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19],
            VEC[i][18:17], int'(VEC[i][16:9]));
      runFrame(VEC[i][8:0]);
    end

    // R8: changes while enabled are ignored
    setup(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 8);
    @(negedge clk);
    cpol = 1'b1; cpha = 1'b1; clkOutEn = 1'b0; lastPulse = 1'b0;
    repeat (2) @(posedge clk);
    #2 chk("R8 sclkOut keeps locked level", 32'(sclkOut), 32'd0);
    runFrame(9'h0B3);
    @(negedge clk) enable = 1'b0;
    @(posedge clk); #2;
    chk("R8 R10 sclkOut takes new cpol once disabled", 32'(sclkOut), 32'd1);

    // R10: abort in mid-frame
    setup(1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 8);
    sendWord(9'h000);
    repeat (3 * 8 + 2) @(posedge clk);
    #2 chk("R10 frame running before abort", 32'(txOut), 32'd0);
    @(negedge clk) enable = 1'b0;
    @(posedge clk); #2;
    chk("R10 txOut after abort", 32'(txOut), 32'd1);
    chk("R10 sclkOut after abort", 32'(sclkOut), 32'd1);
    chk("R10 R9 inReady after abort", 32'(inReady), 32'd0);
    repeat (4) @(posedge clk);
    #2 chk("R10 line stays idle", 32'(txOut), 32'd1);
    @(negedge clk) enable = 1'b1;
    runFrame(9'h033);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule